// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block turns the operation field and the function field of a 32-bit instruction word into the control signals of a single-cycle datapath. It covers seven instructions: register add, register subtract, OR with an immediate, word load, word store, branch on equal, and jump. It is purely combinational. Every output follows the two input fields within the same cycle, and it holds no state.

Register-format instructions share one operation value, and the function field tells them apart. All other instructions are decoded from the operation field alone, and their function bits are ignored. Any pattern that is not one of the seven, whether an unknown operation or an unknown function under the register format, drives every output to zero. The datapath then writes nothing, changes no memory and keeps sequential flow.

Outputs that do not matter for an instruction are driven to 0. The ALU select uses this encoding: 00 add, 01 subtract, 10 OR.

Top module: `sc_main_decode`

## Requirements
- R1: op 6'h00 with fn 6'h20 (add) gives dst_from_rd=1, rf_we=1, alu_op=00, and every other output 0.
- R2: op 6'h00 with fn 6'h22 (subtract) gives dst_from_rd=1, rf_we=1, alu_op=01, and every other output 0.
- R3: op 6'h0D (OR immediate) gives opb_imm=1, rf_we=1, ext_signed=0, alu_op=10, and every other output 0.
- R4: op 6'h23 (load) gives opb_imm=1, ext_signed=1, wb_from_mem=1, rf_we=1, alu_op=00, and every other output 0.
- R5: op 6'h2B (store) gives opb_imm=1, ext_signed=1, dm_we=1, alu_op=00, and every other output 0.
- R6: op 6'h04 (branch on equal) gives br_en=1, alu_op=01, and every other output 0.
- R7: op 6'h02 (jump) gives jmp_en=1, and every other output 0 (alu_op=00).
- R8: for every op other than 6'h00, the value of fn has no effect on any output.
- R9: an op outside the set above, or op 6'h00 with an fn other than 6'h20 or 6'h22, drives all outputs to 0.
- R10: at most one of rf_we, dm_we, br_en and jmp_en is 1 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Operation field of the instruction |
| fn_i | input | 6 | Function field, used only under the register format |
| dst_from_rd | output | 1 | Destination register index is taken from the third register field |
| opb_imm | output | 1 | Second ALU operand is the extended immediate |
| wb_from_mem | output | 1 | Write-back data comes from data memory |
| rf_we | output | 1 | Register file write enable |
| dm_we | output | 1 | Data memory write enable |
| br_en | output | 1 | Conditional branch on equality |
| jmp_en | output | 1 | Unconditional jump |
| ext_signed | output | 1 | Immediate is sign extended (0 means zero extended) |
| alu_op | output | 2 | ALU select: 00 add, 01 subtract, 10 OR |

## Verification
The block has no stored state. A wrong internal instruction class therefore shows at the ports in the same cycle as the input that causes it. A misclassified opcode shows up as a wrong enable pattern: for example, a store that also writes the register file, or an unknown code that still asserts a write. An ALU-select path that disagrees with the class shows as a branch that does not subtract, or a load that does not add. Because each input pair maps to one fixed output word, a check right after each input change sees every such fault.

// File: rtl/sc_dec_pkg.sv
package sc_dec_pkg;
  localparam int OP_W  = 6;
  localparam int FN_W  = 6;
  localparam int ALU_W = 2;

  localparam logic [OP_W-1:0] OPC_REG  = 6'h00;
  localparam logic [OP_W-1:0] OPC_ORI  = 6'h0D;
  localparam logic [OP_W-1:0] OPC_LD   = 6'h23;
  localparam logic [OP_W-1:0] OPC_ST   = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BEQ  = 6'h04;
  localparam logic [OP_W-1:0] OPC_JMP  = 6'h02;
  localparam logic [FN_W-1:0] FNC_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FNC_SUB  = 6'h22;

  typedef enum logic [2:0] {
    CL_NONE, CL_ADD, CL_SUB, CL_ORI, CL_LD, CL_ST, CL_BEQ, CL_JMP
  } insn_cls_e;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_OR  = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic dst_from_rd;
    logic opb_imm;
    logic wb_from_mem;
    logic rf_we;
    logic dm_we;
    logic br_en;
    logic jmp_en;
    logic ext_signed;
  } ctl_t;

  // Register format needs both fields; all other formats use op alone.
  function automatic insn_cls_e classify(input logic [OP_W-1:0] op,
                                         input logic [FN_W-1:0] fn);
    insn_cls_e c;
    c = CL_NONE;
    unique case (op)
      OPC_REG: begin
        if (fn == FNC_ADD)      c = CL_ADD;
        else if (fn == FNC_SUB) c = CL_SUB;
        else                    c = CL_NONE;
      end
      OPC_ORI: c = CL_ORI;
      OPC_LD:  c = CL_LD;
      OPC_ST:  c = CL_ST;
      OPC_BEQ: c = CL_BEQ;
      OPC_JMP: c = CL_JMP;
      default: c = CL_NONE;
    endcase
    return c;
  endfunction

  function automatic alu_op_e alu_for(input insn_cls_e c);
    alu_op_e a;
    unique case (c)
      CL_SUB, CL_BEQ: a = ALU_SUB;
      CL_ORI:         a = ALU_OR;
      default:        a = ALU_ADD;
    endcase
    return a;
  endfunction
endpackage

// File: rtl/sc_insn_class.sv
module sc_insn_class
  import sc_dec_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [FN_W-1:0] fn_i,
  output insn_cls_e       cls_o,
  output logic            known_o
);
  assign cls_o   = classify(op_i, fn_i);
  assign known_o = (cls_o != CL_NONE);
endmodule

// File: rtl/sc_alu_sel.sv
module sc_alu_sel
  import sc_dec_pkg::*;
(
  input  insn_cls_e        cls_i,
  output logic [ALU_W-1:0] alu_o
);
  assign alu_o = alu_for(cls_i);
endmodule

// File: rtl/sc_ctl_table.sv
module sc_ctl_table
  import sc_dec_pkg::*;
(
  input  insn_cls_e cls_i,
  output ctl_t      ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (cls_i)
      CL_ADD, CL_SUB: begin
        ctl_o.dst_from_rd = 1'b1;
        ctl_o.rf_we       = 1'b1;
      end
      CL_ORI: begin
        ctl_o.opb_imm = 1'b1;
        ctl_o.rf_we   = 1'b1;
      end
      CL_LD: begin
        ctl_o.opb_imm     = 1'b1;
        ctl_o.ext_signed  = 1'b1;
        ctl_o.wb_from_mem = 1'b1;
        ctl_o.rf_we       = 1'b1;
      end
      CL_ST: begin
        ctl_o.opb_imm    = 1'b1;
        ctl_o.ext_signed = 1'b1;
        ctl_o.dm_we      = 1'b1;
      end
      CL_BEQ:  ctl_o.br_en  = 1'b1;
      CL_JMP:  ctl_o.jmp_en = 1'b1;
      default: ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/sc_main_decode.sv
module sc_main_decode
  import sc_dec_pkg::*;
(
  input  logic [5:0] op_i,
  input  logic [5:0] fn_i,
  output logic       dst_from_rd,
  output logic       opb_imm,
  output logic       wb_from_mem,
  output logic       rf_we,
  output logic       dm_we,
  output logic       br_en,
  output logic       jmp_en,
  output logic       ext_signed,
  output logic [1:0] alu_op
);
  insn_cls_e        cls;
  logic             insn_known;
  ctl_t             ctl;
  logic [ALU_W-1:0] alu_sel;

  sc_insn_class u_class (.op_i(op_i), .fn_i(fn_i), .cls_o(cls), .known_o(insn_known));
  sc_alu_sel    u_alu   (.cls_i(cls), .alu_o(alu_sel));
  sc_ctl_table  u_table (.cls_i(cls), .ctl_o(ctl));

  assign dst_from_rd = ctl.dst_from_rd;
  assign opb_imm     = ctl.opb_imm;
  assign wb_from_mem = ctl.wb_from_mem;
  assign rf_we       = ctl.rf_we;
  assign dm_we       = ctl.dm_we;
  assign br_en       = ctl.br_en;
  assign jmp_en      = ctl.jmp_en;
  assign ext_signed  = ctl.ext_signed;
  assign alu_op      = alu_sel;

  always_comb begin
    AST_ONE_EFFECT: assert ($onehot0({rf_we, dm_we, br_en, jmp_en})); // R10
    if (!insn_known)
      AST_UNKNOWN_QUIET: assert ({ctl, alu_sel} == '0); // R9
    if (dm_we)
      AST_STORE_SHAPE: assert (!rf_we && opb_imm && ext_signed && alu_sel == ALU_ADD); // R5
    if (br_en)
      AST_BRANCH_SUB: assert (alu_sel == ALU_SUB && !opb_imm); // R6
    if (wb_from_mem)
      AST_LOAD_SHAPE: assert (rf_we && ext_signed && alu_sel == ALU_ADD); // R4
  end
endmodule

// File: tb/sc_main_decode_bench.sv
module sc_main_decode_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] op, fn;
  logic dst_from_rd, opb_imm, wb_from_mem, rf_we, dm_we, br_en, jmp_en, ext_signed;
  logic [1:0] alu_op;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_main_decode u_sc_main_decode (
    .op_i(op), .fn_i(fn), .dst_from_rd(dst_from_rd), .opb_imm(opb_imm),
    .wb_from_mem(wb_from_mem), .rf_we(rf_we), .dm_we(dm_we), .br_en(br_en),
    .jmp_en(jmp_en), .ext_signed(ext_signed), .alu_op(alu_op));

  // Packed as {dst,opb,wbm,rf,dm,br,jmp,ext,alu[1:0]}
  function automatic logic [9:0] expect_word(input logic [5:0] o, input logic [5:0] f);
    case (o)
      6'h00: begin
        if (f == 6'h20)      return 10'b1001_0000_00; // R1
        else if (f == 6'h22) return 10'b1001_0000_01; // R2
        else                 return 10'b0;            // R9
      end
      6'h0D: return 10'b0101_0000_10; // R3
      6'h23: return 10'b0111_0001_00; // R4
      6'h2B: return 10'b0100_1001_00; // R5
      6'h04: return 10'b0000_0100_01; // R6
      6'h02: return 10'b0000_0010_00; // R7
      default: return 10'b0;          // R9
    endcase
  endfunction

  function automatic string req_of(input logic [5:0] o, input logic [5:0] f);
    case (o)
      6'h00: return (f == 6'h20) ? "R1" : (f == 6'h22) ? "R2" : "R9";
      6'h0D: return "R3";
      6'h23: return "R4";
      6'h2B: return "R5";
      6'h04: return "R6";
      6'h02: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [9:0] got_word();
    return {dst_from_rd, opb_imm, wb_from_mem, rf_we, dm_we, br_en, jmp_en, ext_signed, alu_op};
  endfunction

  task automatic apply(input logic [5:0] o, input logic [5:0] f, input string req);
    logic [9:0] exp_w, got;
    @(negedge clk);
    op = o; fn = f;
    #1;
    exp_w = expect_word(o, f);
    got = got_word();
    total++;
    if (got !== exp_w) begin
      bad++;
      $display("FAIL %s op=%h fn=%h got=%b exp=%b", req, o, f, got, exp_w);
    end
    total++;
    if ($countones({rf_we, dm_we, br_en, jmp_en}) > 1) begin
      bad++;
      $display("FAIL R10 op=%h fn=%h got=%b exp=at most one effect", o, f, got);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] o, f, fref;
    logic [9:0] ref_w;
    op = 6'h3F; fn = 6'h3F;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // directed corner cases
    apply(6'h00, 6'h20, "R1");
    apply(6'h00, 6'h22, "R2");
    apply(6'h0D, 6'h00, "R3");
    apply(6'h23, 6'h15, "R4");
    apply(6'h2B, 6'h3F, "R5");
    apply(6'h04, 6'h20, "R6");
    apply(6'h02, 6'h22, "R7");
    apply(6'h00, 6'h21, "R9");
    apply(6'h00, 6'h00, "R9");
    apply(6'h3F, 6'h20, "R9");
    apply(6'h05, 6'h22, "R9");
    // R8: funct sweep for every non-register opcode, compared to fn=0
    for (int k = 1; k < 64; k++) begin
      o = 6'(k);
      fref = 6'h00;
      @(negedge clk); op = o; fn = fref; #1;
      ref_w = got_word();
      for (int j = 0; j < 64; j += 7) begin
        f = 6'(j);
        @(negedge clk); op = o; fn = f; #1;
        total++;
        if (got_word() !== ref_w || ref_w !== expect_word(o, fref)) begin
          bad++;
          $display("FAIL R8 op=%h fn=%h got=%b exp=%b", o, f, got_word(), expect_word(o, fref));
        end
      end
    end
    // constrained random mix, biased toward defined opcodes
    void'($urandom(32'h5EED));
    for (int i = 0; i < 3000; i++) begin
      case ($urandom_range(0, 7))
        0: o = 6'h00;
        1: o = 6'h0D;
        2: o = 6'h23;
        3: o = 6'h2B;
        4: o = 6'h04;
        5: o = 6'h02;
        default: o = 6'($urandom_range(0, 63));
      endcase
      f = ($urandom_range(0, 3) == 0) ? (($urandom_range(0, 1) != 0) ? 6'h20 : 6'h22)
                                      : 6'($urandom_range(0, 63));
      apply(o, f, req_of(o, f));
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule